// File: doc/BRIEF.md
# Expansion-Card Slave Bus Interface

This block is the target side of an asynchronous, strobe-timed 16-bit expansion bus. It samples the address strobe and the two byte strobes through synchronizer chains. It decides whether the cycle falls inside its own address window, and it turns each data-strobe assertion into one access to a local byte-writable memory. That memory answers through a ready handshake after a fixed latency.

While the local access is in progress, the block holds off the bus controller's acknowledge. A static configuration input selects one of two methods for this. In the first method, the block pulls the shared ready line low until the data is available. In the second method, the block raises the acknowledge-override line for the whole selected cycle and then drives its own acknowledge once the access has finished.

Transfers are counted on the data strobes rather than on the address strobe. A locked read-modify-write, in which the address strobe stays low across two strobe phases, therefore produces two separate local accesses. Every slave-driven output is dropped a few clocks after the address strobe returns high. The open-drain electrical drive stays outside the block: each `*_pull` output means "drive the line to its active level".

Top module: `exp_slave_if`

## Requirements
- R1: While reset is high, and after it is released with no bus activity, `rdy_pull`, `ovr_pull`, `ack_pull` and `doe` are 0 and `bus_rdata` is 0.
- R2: In ready mode (`cfg_ovr_mode`=0), a selected cycle sets `rdy_pull` by the third clock edge after `bus_as_n` falls. `rdy_pull` stays 1 until the local access of the current strobe phase completes, at least `WAIT_CYC` and at most `WAIT_CYC`+6 clocks after the strobe assertion. `ovr_pull` and `ack_pull` stay 0 in this mode.
- R3: In override mode (`cfg_ovr_mode`=1), `ovr_pull` is set by the third clock edge after `bus_as_n` falls and is held for the whole selected cycle. `rdy_pull` stays 0. `ack_pull` goes to 1 once the local access completes, within the same latency bounds as R2, and returns to 0 after the data strobes are negated.
- R4: A cycle is selected only when `(bus_addr & WIN_MASK) == WIN_BASE`, where `bus_addr` holds word-address bits 23..1. A cycle outside the window leaves all outputs at 0.
- R5: When `bus_dma_owner_n` is 1 (processor is master), a cycle with `bus_fc` = 3'b111 is ignored and all outputs stay 0. When `bus_dma_owner_n` is 0, `bus_fc` has no effect on selection.
- R6: On a write, `bus_uds_n` low stores `bus_wdata[15:8]` and `bus_lds_n` low stores `bus_wdata[7:0]` into the word indexed by the low `IDX_W` bits of `bus_addr`. The byte lane that is not strobed keeps its old value.
- R7: `doe` is 1 only during a read strobe phase after the local data is ready. `bus_rdata` then shows the stored word with every unstrobed lane forced to 0, and `bus_rdata` is 0 whenever `doe` is 0.
- R8: With `bus_as_n` held low, each fresh data-strobe assertion starts a new local access. After one phase ends, the block re-arms its hold-off (`rdy_pull`=1 in ready mode, `ovr_pull`=1 and `ack_pull`=0 in override mode). A locked read followed by a write both take effect.
- R9: By the third clock edge after `bus_as_n` rises, all of `rdy_pull`, `ovr_pull`, `ack_pull` and `doe` are 0. This also holds when the local access is still in progress, and no late acknowledge or output enable follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ovr_mode | input | 1 | 0: ready hold-off, 1: override plus own acknowledge (static) |
| bus_as_n | input | 1 | Address strobe, active low, asynchronous |
| bus_uds_n | input | 1 | Upper byte strobe (bits 15:8), active low |
| bus_lds_n | input | 1 | Lower byte strobe (bits 7:0), active low |
| bus_read | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | ADDR_W | Word address, bits 23..1 |
| bus_wdata | input | 16 | Write data from the master |
| bus_fc | input | 3 | Cycle-type code from the master |
| bus_dma_owner_n | input | 1 | Low while an expansion DMA master owns the bus |
| rdy_pull | output | 1 | 1 = pull the wired-OR ready line low |
| ovr_pull | output | 1 | 1 = assert acknowledge override |
| ack_pull | output | 1 | 1 = assert own transfer acknowledge |
| doe | output | 1 | Read data output enable |
| bus_rdata | output | 16 | Read data, lane-masked |

## Verification
Two events can coincide: the address strobe rising and a local access still in flight. The bench provokes this by raising the address strobe and the data strobe together a couple of clocks after a read phase starts. At that point the memory is still counting out its latency. The run is judged good if every slave output is low within three edges and stays low while the memory's late ready pulse arrives. A second overlap is checked in the locked read-modify-write: the end of one strobe phase meets the re-arming of the hold-off. Here the bench checks that the hold-off returns before the write phase begins.

// File: rtl/exs_pkg.sv
package exs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BUSY,
    ST_DONE
  } exs_state_t;
endpackage

// File: rtl/exs_sync.sv
module exs_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/exs_mem.sv
module exs_mem #(
  parameter int DEPTH    = 16,
  parameter int WAIT_CYC = 3,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(WAIT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we,
  input  logic [1:0]       be,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      wdata,
  output logic             busy,
  output logic             ack,
  output logic [15:0]      rdata
);
  logic [CNT_W-1:0] cnt;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] ram [DEPTH];
    logic [7:0] rd_b;
    always_ff @(posedge clk) begin
      if (req && we && be[g]) ram[idx] <= wdata[g*8 +: 8];
      if (req) rd_b <= ram[idx];
    end
    assign rdata[g*8 +: 8] = rd_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ack <= 1'b0;
    end else begin
      ack <= (cnt == CNT_W'(1));
      if (req)             cnt <= CNT_W'(WAIT_CYC);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);

  // R8
  req_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> !busy);
endmodule

// File: rtl/exs_ctrl.sv
module exs_ctrl
  import exs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ovr_mode,
  input  logic        as_n_s,
  input  logic        uds_n_s,
  input  logic        lds_n_s,
  input  logic        sel_ok,
  input  logic        rd_in,
  input  logic        mem_busy,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata,
  output logic        mem_req,
  output logic [1:0]  mem_be,
  output logic        rdy_pull,
  output logic        ovr_pull,
  output logic        ack_pull,
  output logic        doe,
  output logic [15:0] rdata
);
  exs_state_t st, nxt;
  logic       ds_any;
  logic       rd_q;
  logic [1:0] lanes_q;
  logic [15:0] lane_mask;

  assign ds_any    = !uds_n_s || !lds_n_s;
  assign mem_be    = {!uds_n_s, !lds_n_s};
  assign lane_mask = {{8{lanes_q[1]}}, {8{lanes_q[0]}}};

  always_comb begin
    nxt     = st;
    mem_req = 1'b0;
    if (as_n_s) begin
      nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (sel_ok) nxt = ST_WAIT;
        ST_WAIT: if (ds_any && !mem_busy) begin
          nxt     = ST_BUSY;
          mem_req = 1'b1;
        end
        ST_BUSY: if (mem_ack) nxt = ST_DONE;
        ST_DONE: if (!ds_any) nxt = ST_WAIT;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      rd_q     <= 1'b0;
      lanes_q  <= 2'b00;
      rdy_pull <= 1'b0;
      ovr_pull <= 1'b0;
      ack_pull <= 1'b0;
      doe      <= 1'b0;
      rdata    <= '0;
    end else begin
      st <= nxt;
      if (mem_req) begin
        rd_q    <= rd_in;
        lanes_q <= mem_be;
      end
      rdy_pull <= !ovr_mode && (nxt == ST_WAIT || nxt == ST_BUSY);
      ovr_pull <= ovr_mode && (nxt != ST_IDLE);
      ack_pull <= ovr_mode && (nxt == ST_DONE);
      doe      <= (nxt == ST_DONE) && rd_q;
      rdata    <= ((nxt == ST_DONE) && rd_q) ? (mem_rdata & lane_mask) : '0;
    end
  end

  // R9
  release_on_as_chk: assert property (@(posedge clk) disable iff (rst)
    as_n_s |=> !(rdy_pull || ovr_pull || ack_pull || doe));
  // R3
  ack_under_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    ack_pull |-> ovr_pull);
  // R7
  doe_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(doe) |-> $past(mem_ack));
  // R3
  ack_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_pull) |-> $past(mem_ack));
endmodule

// File: rtl/exp_slave_if.sv
module exp_slave_if #(
  parameter int              ADDR_W      = 23,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 23'h080000,
  parameter logic [ADDR_W-1:0] WIN_MASK  = 23'h7FFFF0,
  parameter int              DEPTH       = 16,
  parameter int              WAIT_CYC    = 3,
  parameter int              SYNC_STAGES = 2,
  localparam int             IDX_W       = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_ovr_mode,
  input  logic            bus_as_n,
  input  logic            bus_uds_n,
  input  logic            bus_lds_n,
  input  logic            bus_read,
  input  logic [ADDR_W:1] bus_addr,
  input  logic [15:0]     bus_wdata,
  input  logic [2:0]      bus_fc,
  input  logic            bus_dma_owner_n,
  output logic            rdy_pull,
  output logic            ovr_pull,
  output logic            ack_pull,
  output logic            doe,
  output logic [15:0]     bus_rdata
);
  logic [2:0]  strb_s;
  logic        hit, fc_ok, sel_ok;
  logic        mem_req, mem_busy, mem_ack;
  logic [1:0]  mem_be;
  logic [15:0] mem_rdata;

  exs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_as_n, bus_uds_n, bus_lds_n}),
    .q   (strb_s)
  );

  assign hit    = ((bus_addr & WIN_MASK) == WIN_BASE);
  assign fc_ok  = !bus_dma_owner_n || (bus_fc != 3'b111);
  assign sel_ok = hit && fc_ok;

  exs_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ovr_mode  (cfg_ovr_mode),
    .as_n_s    (strb_s[2]),
    .uds_n_s   (strb_s[1]),
    .lds_n_s   (strb_s[0]),
    .sel_ok    (sel_ok),
    .rd_in     (bus_read),
    .mem_busy  (mem_busy),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_be    (mem_be),
    .rdy_pull  (rdy_pull),
    .ovr_pull  (ovr_pull),
    .ack_pull  (ack_pull),
    .doe       (doe),
    .rdata     (bus_rdata)
  );

  exs_mem #(.DEPTH(DEPTH), .WAIT_CYC(WAIT_CYC)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .req   (mem_req),
    .we    (!bus_read),
    .be    (mem_be),
    .idx   (bus_addr[IDX_W:1]),
    .wdata (bus_wdata),
    .busy  (mem_busy),
    .ack   (mem_ack),
    .rdata (mem_rdata)
  );

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> !(rdy_pull || ovr_pull || ack_pull || doe));
  // R2
  one_method_chk: assert property (@(posedge clk) disable iff (rst)
    !(rdy_pull && ovr_pull));
endmodule

// File: tb/tb_exp_slave_if.sv
module tb_exp_slave_if;
  localparam int WAIT_CYC = 3;
  localparam logic [22:0] BASE = 23'h080000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_ovr_mode = 1'b0;
  logic        bus_as_n = 1'b1, bus_uds_n = 1'b1, bus_lds_n = 1'b1;
  logic        bus_read = 1'b1;
  logic [23:1] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [2:0]  bus_fc = 3'b101;
  logic        bus_dma_owner_n = 1'b1;
  logic        rdy_pull, ovr_pull, ack_pull, doe;
  logic [15:0] bus_rdata;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;
  logic [15:0] sh [16];

  always #2.5 clk = ~clk;

  exp_slave_if #(.WAIT_CYC(WAIT_CYC)) dut (
    .clk(clk), .rst(rst), .cfg_ovr_mode(cfg_ovr_mode),
    .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
    .bus_read(bus_read), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_fc(bus_fc), .bus_dma_owner_n(bus_dma_owner_n),
    .rdy_pull(rdy_pull), .ovr_pull(ovr_pull), .ack_pull(ack_pull),
    .doe(doe), .bus_rdata(bus_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {rdy_pull, ovr_pull, ack_pull, doe};
  endfunction

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic as_on(logic [22:0] a);
    @(negedge clk);
    bus_addr = a;
    bus_as_n = 1'b0;
    settle(3);
    if (cfg_ovr_mode) chk("R3 select", {rdy_pull, ovr_pull}, 2'b01);
    else              chk("R2 select", {rdy_pull, ovr_pull}, 2'b10);
  endtask

  task automatic as_off();
    @(negedge clk);
    bus_as_n = 1'b1;
    settle(3);
    chk("R9 release", outs(), 4'b0000);
  endtask

  task automatic phase(logic rd, logic [1:0] ln, logic [15:0] wd, output logic [15:0] got);
    int n = 0;
    bus_read  = rd;
    bus_wdata = wd;
    bus_uds_n = !ln[1];
    bus_lds_n = !ln[0];
    do begin
      @(negedge clk);
      n++;
    end while ((cfg_ovr_mode ? !ack_pull : rdy_pull) && n < 60);
    chk(cfg_ovr_mode ? "R3 latency" : "R2 latency",
        (n >= WAIT_CYC && n <= WAIT_CYC + 6), 1);
    chk("R7 doe", doe, rd);
    got = bus_rdata;
    bus_uds_n = 1'b1;
    bus_lds_n = 1'b1;
    settle(4);
    chk("R8 rearm", outs(), cfg_ovr_mode ? 4'b0100 : 4'b1000);
    chk("R7 idle data", bus_rdata, 16'h0);
  endtask

  task automatic wr(int i, logic [1:0] ln, logic [15:0] wd);
    logic [15:0] g;
    as_on(BASE + 23'(i));
    phase(1'b0, ln, wd, g);
    as_off();
    if (ln[1]) sh[i][15:8] = wd[15:8];
    if (ln[0]) sh[i][7:0]  = wd[7:0];
  endtask

  task automatic rd_chk(int i, logic [1:0] ln, string tag);
    logic [15:0] g;
    as_on(BASE + 23'(i));
    phase(1'b1, ln, 16'h0, g);
    as_off();
    chk(tag, g, sh[i] & {{8{ln[1]}}, {8{ln[0]}}});
  endtask

  task automatic ignored(logic [22:0] a, logic [2:0] fc, logic own_n, string tag);
    @(negedge clk);
    bus_addr = a; bus_fc = fc; bus_dma_owner_n = own_n;
    bus_read = 1'b1; bus_as_n = 1'b0;
    settle(2);
    bus_uds_n = 1'b0; bus_lds_n = 1'b0;
    settle(10);
    chk(tag, {outs(), bus_rdata}, 20'h0);
    bus_uds_n = 1'b1; bus_lds_n = 1'b1; bus_as_n = 1'b1;
    bus_fc = 3'b101; bus_dma_owner_n = 1'b1;
    settle(4);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1;
        nfail++; nchk++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] g;
    settle(3);
    chk("R1 in reset", {outs(), bus_rdata}, 20'h0);
    rst = 1'b0;
    settle(5);
    chk("R1 after reset", {outs(), bus_rdata}, 20'h0);

    for (int m = 0; m < 2; m++) begin
      cfg_ovr_mode = m[0];
      settle(2);
      for (int i = 0; i < 16; i++)
        wr(i, 2'b11, 16'hA5C3 ^ 16'(i * 16'h0123) ^ 16'(m));
      for (int i = 0; i < 16; i++) begin
        wr(i, 2'b10, 16'(i * 16'h1111) ^ 16'h3C00);
        wr(i, 2'b01, 16'(i * 16'h0707) ^ 16'h005A);
        rd_chk(i, 2'b11, "R6 word");
        rd_chk(i, 2'b10, "R7 upper lane");
        rd_chk(i, 2'b01, "R7 lower lane");
      end
      // R8 locked read-modify-write
      as_on(BASE + 23'd5);
      phase(1'b1, 2'b11, 16'h0, g);
      chk("R8 locked read", g, sh[5]);
      phase(1'b0, 2'b11, g + 16'd1, g);
      as_off();
      sh[5] = sh[5] + 16'd1;
      rd_chk(5, 2'b11, "R8 locked write");
    end

    // R4 window misses
    ignored(BASE + 23'h10, 3'b101, 1'b1, "R4 miss above");
    ignored(23'h000005, 3'b101, 1'b1, "R4 miss low");
    // R5 function-code qualification
    ignored(BASE + 23'd2, 3'b111, 1'b1, "R5 cpu space");
    rd_chk(2, 2'b11, "R5 ignored left data");
    bus_dma_owner_n = 1'b0; bus_fc = 3'b111;
    rd_chk(3, 2'b11, "R5 dma fc ignored");
    bus_dma_owner_n = 1'b1; bus_fc = 3'b101;

    // R9 abort while local access is in flight
    cfg_ovr_mode = 1'b0;
    settle(2);
    as_on(BASE + 23'd7);
    bus_read = 1'b1; bus_uds_n = 1'b0; bus_lds_n = 1'b0;
    settle(2);
    bus_as_n = 1'b1; bus_uds_n = 1'b1; bus_lds_n = 1'b1;
    settle(3);
    chk("R9 abort release", outs(), 4'b0000);
    for (int k = 0; k < 8; k++) begin
      settle(1);
      chk("R9 no late output", {outs(), bus_rdata}, 20'h0);
    end
    rd_chk(7, 2'b11, "R9 after abort");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule